// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block gathers single-cycle event pulses from device logic into sticky status bits. It drives a level-style interrupt line toward the host while any bit is set. Bit 0 flags that the device wants a new buffer address, which also means that data has been delivered. Bit 1 flags that the device has acknowledged a shutdown request.

The host services the line by reading the register through a memory-mapped read port. The read returns the bits and clears each bit that it returned as set, so no separate acknowledge write is needed. An event that lands on the same clock as the read is not lost: its bit is set after the read. The register is read-only, and a read that finds nothing pending is harmless.

Each status bit is a two-state machine. `ST_IDLE` moves to `ST_PEND` on an event pulse. `ST_PEND` returns to `ST_IDLE` on a read with no coinciding pulse. `ST_PEND` stays in `ST_PEND` on a read that coincides with a pulse, and it also stays there while no read arrives.

Top module: `irq_stat_reg`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` sets status bit i from the next clock edge onward. Bit 0 is the address-request/data-available flag and bit 1 is the shutdown-acknowledge flag.
- R2: `rd_data` is loaded on each clock edge where `rd_stb` is high. It takes the status bits as they stood before that edge in `rd_data[1:0]`, with all higher bits zero. On edges without `rd_stb`, `rd_data` holds its value.
- R3: A read clears every status bit that it returned as '1'.
- R4: When an event pulse arrives on the same edge as a read, its bit is '1' after that edge. This holds whether the read returned that bit as '0' or as '1'.
- R5: `irq` is high whenever any status bit is '1'. It falls in the cycle after the read that clears the last set bit.
- R6: A read while no bit is set returns zero and leaves `irq` low.
- R7: A repeated pulse on a bit that is already set has no further effect. A single read clears that bit.
- R8: While `rst_n` is low, both status bits are cleared, `irq` is low and `rd_data` is zero.
- R9: Host writes (`wr_en` with any `wr_data`) change no status bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | NUM_SRC | Single-cycle event pulses, one per status bit |
| rd_stb | input | 1 | Register read strobe, one cycle per read |
| wr_en | input | 1 | Host write strobe to this address (ignored) |
| wr_data | input | DATA_W | Host write data (ignored) |
| rd_data | output | DATA_W | Read data, loaded on a read |
| irq | output | 1 | Level interrupt, high while any bit is set |

## Verification
The assertions assume that `rd_stb` and `evt_pulse` are synchronous to `clk` and stable around its rising edge. They also assume that each read is a single strobe cycle. The bench changes every input only on the falling edge and returns each input to zero one cycle later, so strobes and pulses are always exactly one clock wide. Coinciding reads and events are driven on purpose, because the capture rules depend on them.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    // Per-bit status state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } bit_state_e;

    // Bit positions the host driver decodes
    localparam int unsigned BIT_ADDR_REQ = 0;
    localparam int unsigned BIT_SHUT_ACK = 1;

endpackage

// File: rtl/irq_stat_bit.sv
module irq_stat_bit
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd,
    output logic pending
);

    bit_state_e state_q;
    bit_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: an event always wins over a coinciding read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (rd && !evt) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_PEND: pending = 1'b1;
            default: pending = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_stat_rdport.sv
module irq_stat_rdport #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [NUM_SRC-1:0] status,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic [DATA_W-1:0] rd_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd) begin
            rd_data_q <= {{PAD_W{1'b0}}, status};
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               rd_stb,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq
);

    logic [NUM_SRC-1:0] status;

    // The register is read-only; host writes are discarded
    logic unused_wr;
    assign unused_wr = ^{wr_en, wr_data};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        irq_stat_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_pulse[i]),
            .rd      (rd_stb),
            .pending (status[i])
        );
    end

    irq_stat_rdport #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (rd_stb),
        .status  (status),
        .rd_data (rd_data)
    );

    assign irq = |status;

endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
    parameter int unsigned NUM_SRC = 2,
    parameter int unsigned DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               rd_stb,
    input logic               wr_en,
    input logic [NUM_SRC-1:0] status,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq
);

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> irq);  // R4

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[NUM_SRC-1:0] == $past(status)));  // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));  // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && evt_pulse == '0) |=> !irq);  // R3

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_stb) |=> irq);  // R5

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_stb && evt_pulse == '0) |=> $stable(status));  // R9

endmodule

bind irq_stat_reg irq_stat_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .rd_stb    (rd_stb),
    .wr_en     (wr_en),
    .status    (status),
    .rd_data   (rd_data),
    .irq       (irq)
);

// File: tb/tb_irq_stat_reg.sv
`timescale 1ns/1ps
module tb_irq_stat_reg;

    localparam int unsigned NS = 2;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [DW-1:0] wdat = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NS-1:0] model = '0;
    logic [DW-1:0] last_exp = '0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;  // 250 MHz

    irq_stat_reg #(.NUM_SRC(NS), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .rd_stb(rd),
        .wr_en(wr), .wr_data(wdat), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected read value one edge after each read
    always @(posedge clk) begin
        logic take;
        take = rst_n && rd;
        #1;
        if (take) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data == e, t, rd_data, e);
        end
    end

    // Driver: one stimulus cycle, expectation pushed from the bench model
    task automatic step(input logic [NS-1:0] e, input logic r, input logic w,
                        input string tag);
        @(negedge clk);
        evt = e; rd = r; wr = w; wdat = w ? 32'hFFFF_FFFF : '0;
        if (r) begin
            last_exp = {{(DW-NS){1'b0}}, model};
            exp_q.push_back(last_exp);
            tag_q.push_back(tag);
            model = e;
        end else begin
            model = model | e;
        end
        @(negedge clk);
        evt = '0; rd = 1'b0; wr = 1'b0; wdat = '0;
        chk(irq == (|model), {tag, " R5 irq"}, {31'b0, irq}, {31'b0, |model});
        if (!r) chk(rd_data == last_exp, {tag, " R2 hold"}, rd_data, last_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R8 reset irq", {31'b0, irq}, '0);
        chk(rd_data == '0, "R8 reset rd_data", rd_data, '0);
        rst_n = 1'b1;

        step(2'b00, 1, 0, "R6 empty read");
        step(2'b01, 0, 0, "R1 set addr bit");
        step(2'b00, 1, 0, "R2 R3 read clears");
        step(2'b10, 0, 0, "R1 set shutdown bit");
        step(2'b10, 0, 0, "R7 repeat pulse");
        step(2'b00, 1, 0, "R7 single read clears");
        step(2'b00, 1, 0, "R6 read after clear");
        step(2'b11, 0, 0, "R1 set both");
        step(2'b00, 0, 1, "R9 write ignored");
        step(2'b00, 1, 0, "R9 bits intact");
        step(2'b01, 0, 0, "R4 prep");
        step(2'b10, 1, 0, "R4 event on zero bit");
        step(2'b00, 1, 0, "R4 kept bit");
        step(2'b01, 0, 0, "R4 prep set bit");
        step(2'b01, 1, 0, "R4 event on set bit");
        step(2'b00, 1, 0, "R4 set bit kept");
        step(2'b01, 0, 0, "R5 first");
        step(2'b10, 0, 0, "R5 second");
        step(2'b00, 1, 0, "R5 drop after read");
        step(2'b11, 0, 0, "R8 prep");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R8 mid reset irq", {31'b0, irq}, '0);
        chk(rd_data == '0, "R8 mid reset rd_data", rd_data, '0);
        rst_n = 1'b1;
        model = '0;
        last_exp = '0;
        step(2'b00, 1, 0, "R8 bits cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule